// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block turns one write of a command word into a single request toward a memory card, then collects the card's reply and decides the outcome. The command word carries the command index, whether a reply is expected, whether the reply is long, two mode bits this block does not support, and an enable bit. The argument is sampled on the same write. The request leaves on a valid/ready port as a 6-bit index plus the argument.

The card answers with a byte stream. Each byte comes with a last marker. A reply can also carry no bytes at all, or it can be a rejection. When the reply ends, the block raises exactly one of three outcome flags: response captured, command sent, or timeout. A captured reply is packed big-endian into four 32-bit response words, and those words change only on a successful capture. After each command the enable bit of the stored command word clears itself, so software can see that the command has finished.

Top module: `sdcmd_capture`

## Requirements
- R1: After reset, busy, all three outcome flags, req_valid, the stored command word and all four response words read 0.
- R2: A command write with bit 10 set, and bits 8 and 9 clear, raises req_valid with req_index equal to bits 5:0 of the word and req_arg equal to the sampled argument. Both stay stable until req_ready is seen.
- R3: If bit 6 is clear and the card does not reject, the command-sent flag is set and the response words keep their previous values.
- R4: If bit 6 is set, the reply is a timeout in each of these cases: it carries 0 bytes; it carries 4 bytes and bit 7 is set; its byte count is neither 4 nor 16. A timeout leaves the response words unchanged.
- R5: Received bytes are packed big-endian. Byte k lands in word k/4, at bits 31-8*(k mod 4) down to 24-8*(k mod 4).
- R6: A 4-byte reply with bit 7 clear fills word 0, writes 0 to words 1 to 3, and sets the response-captured flag.
- R7: A 16-byte reply fills all four words, with bit 0 of word 3 forced to 0, and sets the response-captured flag.
- R8: A reply marked as a rejection gives a timeout, whatever bits 6 and 7 hold.
- R9: An enabled command with bit 8 (interrupt mode) or bit 9 (pending mode) set issues no request and gives a timeout.
- R10: When a command completes, the stored command word reads back as written, with bit 10 cleared. A write with bit 10 clear only stores the word: no request is issued and the flags are left as they were.
- R11: A command write that arrives while busy is high is ignored.
- R12: An enabled command clears all three flags when it starts. Exactly one flag is set when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word being written |
| cmd_arg | input | 32 | Argument, sampled on an enabled command write |
| req_valid | output | 1 | A request toward the card is pending |
| req_ready | input | 1 | The card takes the request |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rply_valid | input | 1 | A reply beat is present |
| rply_ready | output | 1 | The block is collecting the reply |
| rply_byte | input | 8 | Reply data byte |
| rply_last | input | 1 | This beat ends the reply |
| rply_empty | input | 1 | With rply_last: this beat carries no byte |
| rply_reject | input | 1 | The card rejects the command; ends the reply |
| cmd_word | output | 32 | Stored command word (enable self-clears) |
| resp_w0 | output | 32 | Response word 0 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |
| flag_rsp_end | output | 1 | Response captured |
| flag_sent | output | 1 | Command sent without a reply expected |
| flag_timeout | output | 1 | Timeout or rejection |
| busy | output | 1 | A command is in progress |

## Verification
Reply lengths of 0, 4, 5, 16 and 17 bytes are applied under the short and long expectations. These separate the single accepted short length from the single accepted long length and from the over-run that the saturating count must catch. Distinct byte values, and a last byte with bit 0 set, show whether the packing order is big-endian and whether the final bit is forced clear. Response words are compared before and after a sent-only command, a timeout and a rejection, which shows that staging is kept apart from commit. Unsupported mode bits, a write without enable, and a write during a busy command check that no request leaves and that the stored word and flags behave as specified.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int unsigned CW_IDX_W    = 6;
    localparam int unsigned CW_RESP_BIT = 6;
    localparam int unsigned CW_LONG_BIT = 7;
    localparam int unsigned CW_INTR_BIT = 8;
    localparam int unsigned CW_PEND_BIT = 9;
    localparam int unsigned CW_EN_BIT   = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic rsp_end;
        logic sent;
        logic timeout;
    } outcome_t;
endpackage

// File: rtl/sdcmd_field_dec.sv
module sdcmd_field_dec
    import sdcmd_pkg::*;
(
    input  logic [CW_EN_BIT:0]    word,
    output logic [CW_IDX_W-1:0]   index,
    output logic                  want_resp,
    output logic                  want_long,
    output logic                  unsup,
    output logic                  enable
);
    always_comb begin
        index     = word[CW_IDX_W-1:0];
        want_resp = word[CW_RESP_BIT];
        want_long = word[CW_LONG_BIT];
        unsup     = word[CW_INTR_BIT] | word[CW_PEND_BIT];
        enable    = word[CW_EN_BIT];
    end
endmodule

// File: rtl/sdcmd_resp_pack.sv
module sdcmd_resp_pack #(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BPW   = WORD_W / 8,
    localparam int unsigned TOTAL = WORDS * BPW,
    localparam int unsigned CNT_W = $clog2(TOTAL + 2)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [7:0]                     byte_in,
    output logic [WORDS-1:0][WORD_W-1:0]   words,
    output logic [CNT_W-1:0]               cnt
);
    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] words;
        logic [CNT_W-1:0]             cnt;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d = '0;
        end else if (push) begin
            for (int w = 0; w < int'(WORDS); w++) begin
                for (int b = 0; b < int'(BPW); b++) begin
                    if (pk_q.cnt == CNT_W'(w * int'(BPW) + b)) begin
                        pk_d.words[w][WORD_W-1-8*b -: 8] = byte_in;
                    end
                end
            end
            // saturate one above the longest legal reply
            if (pk_q.cnt <= CNT_W'(TOTAL)) begin
                pk_d.cnt = pk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign words = pk_q.words;
    assign cnt   = pk_q.cnt;

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.cnt <= CNT_W'(TOTAL + 1)); // R4
endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture
    import sdcmd_pkg::*;
#(
    parameter int unsigned CMD_W      = 32,
    parameter int unsigned ARG_W      = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned RESP_WORDS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [CMD_W-1:0]      cmd_wdata,
    input  logic [ARG_W-1:0]      cmd_arg,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [CW_IDX_W-1:0]   req_index,
    output logic [ARG_W-1:0]      req_arg,
    input  logic                  rply_valid,
    output logic                  rply_ready,
    input  logic [7:0]            rply_byte,
    input  logic                  rply_last,
    input  logic                  rply_empty,
    input  logic                  rply_reject,
    output logic [CMD_W-1:0]      cmd_word,
    output logic [WORD_W-1:0]     resp_w0,
    output logic [WORD_W-1:0]     resp_w1,
    output logic [WORD_W-1:0]     resp_w2,
    output logic [WORD_W-1:0]     resp_w3,
    output logic                  flag_rsp_end,
    output logic                  flag_sent,
    output logic                  flag_timeout,
    output logic                  busy
);
    localparam int unsigned BPW         = WORD_W / 8;
    localparam int unsigned SHORT_BYTES = BPW;
    localparam int unsigned LONG_BYTES  = RESP_WORDS * BPW;
    localparam int unsigned CNT_W       = $clog2(LONG_BYTES + 2);

    typedef struct packed {
        seq_state_e                        st;
        logic [CMD_W-1:0]                  cmd;
        logic [ARG_W-1:0]                  arg;
        logic                              rej;
        logic [RESP_WORDS-1:0][WORD_W-1:0] resp;
        outcome_t                          flags;
    } regs_t;

    regs_t r_d, r_q;

    logic [CW_EN_BIT:0]               dec_in;
    logic [CW_IDX_W-1:0]              dec_index;
    logic                             dec_resp, dec_long, dec_unsup, dec_en;
    logic                             pk_clr, pk_push, len_bad;
    logic [RESP_WORDS-1:0][WORD_W-1:0] pk_words;
    logic [CNT_W-1:0]                 pk_cnt;

    // decode the incoming word while idle, the held word otherwise
    assign dec_in = (r_q.st == ST_IDLE) ? cmd_wdata[CW_EN_BIT:0] : r_q.cmd[CW_EN_BIT:0];

    sdcmd_field_dec u_dec (
        .word      (dec_in),
        .index     (dec_index),
        .want_resp (dec_resp),
        .want_long (dec_long),
        .unsup     (dec_unsup),
        .enable    (dec_en)
    );

    sdcmd_resp_pack #(
        .WORDS  (RESP_WORDS),
        .WORD_W (WORD_W)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pk_clr),
        .push    (pk_push),
        .byte_in (rply_byte),
        .words   (pk_words),
        .cnt     (pk_cnt)
    );

    always_comb begin
        len_bad = (pk_cnt == '0)
               || (pk_cnt == CNT_W'(SHORT_BYTES) && dec_long)
               || (pk_cnt != CNT_W'(SHORT_BYTES) && pk_cnt != CNT_W'(LONG_BYTES));
    end

    always_comb begin
        r_d     = r_q;
        pk_clr  = 1'b0;
        pk_push = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    r_d.cmd = cmd_wdata;
                    if (dec_en) begin
                        r_d.arg   = cmd_arg;
                        r_d.flags = '0;
                        r_d.rej   = dec_unsup;
                        pk_clr    = 1'b1;
                        r_d.st    = dec_unsup ? ST_FINISH : ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (req_ready) r_d.st = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (rply_valid) begin
                    if (rply_reject) begin
                        r_d.rej = 1'b1;
                        r_d.st  = ST_FINISH;
                    end else begin
                        pk_push = !rply_empty;
                        if (rply_last) r_d.st = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                r_d.cmd[CW_EN_BIT] = 1'b0;
                r_d.st             = ST_IDLE;
                if (r_q.rej) begin
                    r_d.flags.timeout = 1'b1;
                end else if (!dec_resp) begin
                    r_d.flags.sent = 1'b1;
                end else if (len_bad) begin
                    r_d.flags.timeout = 1'b1;
                end else begin
                    r_d.flags.rsp_end = 1'b1;
                    if (pk_cnt == CNT_W'(SHORT_BYTES)) begin
                        r_d.resp    = '0;
                        r_d.resp[0] = pk_words[0];
                    end else begin
                        r_d.resp                  = pk_words;
                        r_d.resp[RESP_WORDS-1][0] = 1'b0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid    = (r_q.st == ST_ISSUE);
    assign req_index    = dec_index;
    assign req_arg      = r_q.arg;
    assign rply_ready   = (r_q.st == ST_COLLECT);
    assign cmd_word     = r_q.cmd;
    assign resp_w0      = r_q.resp[0];
    assign resp_w1      = r_q.resp[1];
    assign resp_w2      = r_q.resp[2];
    assign resp_w3      = r_q.resp[RESP_WORDS-1];
    assign flag_rsp_end = r_q.flags.rsp_end;
    assign flag_sent    = r_q.flags.sent;
    assign flag_timeout = r_q.flags.timeout;
    assign busy         = (r_q.st != ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg)); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_rsp_end, flag_sent, flag_timeout})); // R12
    AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $countones({flag_rsp_end, flag_sent, flag_timeout}) == 1); // R12
    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_word[CW_EN_BIT]); // R10
    AST_W3_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rsp_end) |-> !resp_w3[0]); // R7
endmodule

// File: tb/sdcmd_capture_bench.sv
module sdcmd_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [31:0] cmd_wdata, cmd_arg;
    logic        req_valid, req_ready;
    logic [5:0]  req_index;
    logic [31:0] req_arg;
    logic        rply_valid, rply_ready, rply_last, rply_empty, rply_reject;
    logic [7:0]  rply_byte;
    logic [31:0] cmd_word, resp_w0, resp_w1, resp_w2, resp_w3;
    logic        flag_rsp_end, flag_sent, flag_timeout, busy;

    always #2 clk = ~clk;

    sdcmd_capture u_sdcmd_capture (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_arg(cmd_arg),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
        .rply_valid(rply_valid), .rply_ready(rply_ready), .rply_byte(rply_byte),
        .rply_last(rply_last), .rply_empty(rply_empty), .rply_reject(rply_reject),
        .cmd_word(cmd_word), .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2),
        .resp_w3(resp_w3), .flag_rsp_end(flag_rsp_end), .flag_sent(flag_sent),
        .flag_timeout(flag_timeout), .busy(busy)
    );

    localparam logic [31:0] EN = 32'h400, RSP = 32'h40, LNG = 32'h80, INTR = 32'h100, PEND = 32'h200;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0]  bq [0:19];
    logic [31:0] ew [0:3];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int n, input logic [7:0] seed);
        for (int k = 0; k < 20; k++) bq[k] = 8'(seed + 8'(k * 17));
        bq[n > 0 ? n - 1 : 0] = 8'hFF;
    endtask

    task automatic expect_words(input int n);
        for (int w = 0; w < 4; w++) ew[w] = 32'h0;
        for (int k = 0; k < n; k++) ew[k / 4] = ew[k / 4] | (32'(bq[k]) << (24 - 8 * (k % 4)));
        if (n == 16) ew[3][0] = 1'b0;
    endtask

    task automatic write_cmd(input logic [31:0] w, input logic [31:0] a);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = w; cmd_arg = a;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // kind: 0 bytes, 1 empty, 2 reject
    task automatic serve(input int n, input int kind, input logic [31:0] w, input logic [31:0] a, input bit poke);
        int guard = 0;
        while (!req_valid && guard < 20) begin @(negedge clk); guard++; end
        chk("R2", "req_valid", 32'(req_valid), 32'h1);
        chk("R2", "req_index", 32'(req_index), 32'(w[5:0]));
        chk("R2", "req_arg", req_arg, a);
        @(negedge clk);
        chk("R2", "req held while not ready", 32'(req_valid), 32'h1);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (poke) begin
            cmd_wr = 1'b1; cmd_wdata = 32'hFFFF_FFFF; cmd_arg = 32'h0;
            @(negedge clk);
            cmd_wr = 1'b0;
        end
        if (kind == 2) begin
            rply_valid = 1'b1; rply_reject = 1'b1;
            @(negedge clk);
        end else if (kind == 1) begin
            rply_valid = 1'b1; rply_last = 1'b1; rply_empty = 1'b1;
            @(negedge clk);
        end else begin
            for (int k = 0; k < n; k++) begin
                rply_valid = 1'b1; rply_byte = bq[k]; rply_last = (k == n - 1);
                @(negedge clk);
            end
        end
        rply_valid = 1'b0; rply_last = 1'b0; rply_empty = 1'b0; rply_reject = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int guard = 0;
        while (busy && guard < 50) begin @(negedge clk); guard++; end
        chk(req, "returned idle", 32'(busy), 32'h0);
    endtask

    task automatic chk_flags(input string req, input bit r, input bit s, input bit t);
        chk(req, "flags {rsp_end,sent,timeout}", {29'h0, flag_rsp_end, flag_sent, flag_timeout}, {29'h0, r, s, t});
    endtask

    task automatic chk_resp(input string req);
        chk(req, "resp_w0", resp_w0, ew[0]);
        chk(req, "resp_w1", resp_w1, ew[1]);
        chk(req, "resp_w2", resp_w2, ew[2]);
        chk(req, "resp_w3", resp_w3, ew[3]);
    endtask

    task automatic t_reset;
        chk("R1", "busy", 32'(busy), 32'h0);
        chk("R1", "req_valid", 32'(req_valid), 32'h0);
        chk("R1", "cmd_word", cmd_word, 32'h0);
        chk_flags("R1", 1'b0, 1'b0, 1'b0);
        for (int w = 0; w < 4; w++) ew[w] = 32'h0;
        chk_resp("R1");
    endtask

    task automatic t_short;
        logic [31:0] w = EN | RSP | 32'd17;
        fill(4, 8'h12);
        write_cmd(w, 32'hCAFE_0001);
        serve(4, 0, w, 32'hCAFE_0001, 1'b0);
        wait_idle("R6");
        expect_words(4);
        chk_flags("R6", 1'b1, 1'b0, 1'b0);
        chk_resp("R5");
        chk("R10", "enable self-clears", cmd_word, w & ~EN);
    endtask

    task automatic t_long(input logic [31:0] w);
        fill(16, 8'h31);
        write_cmd(w, 32'h0000_BEEF);
        serve(16, 0, w, 32'h0000_BEEF, 1'b0);
        wait_idle("R7");
        expect_words(16);
        chk_flags("R7", 1'b1, 1'b0, 1'b0);
        chk_resp("R7");
    endtask

    task automatic t_sent;
        logic [31:0] w = EN | 32'd0;
        write_cmd(w, 32'h1234_5678);
        serve(0, 1, w, 32'h1234_5678, 1'b1);
        wait_idle("R3");
        chk_flags("R3", 1'b0, 1'b1, 1'b0);
        chk_resp("R3");
        chk("R11", "write while busy ignored", cmd_word, w & ~EN);
    endtask

    task automatic t_bad(input logic [31:0] w, input int n, input int kind, input string req);
        fill(n, 8'h77);
        write_cmd(w, 32'h0BAD_0000 | 32'(n));
        serve(n, kind, w, 32'h0BAD_0000 | 32'(n), 1'b0);
        wait_idle(req);
        chk_flags(req, 1'b0, 1'b0, 1'b1);
        chk_resp(req);
    endtask

    task automatic t_unsup(input logic [31:0] mode);
        logic [31:0] w = EN | RSP | mode | 32'd5;
        bit seen = 1'b0;
        write_cmd(w, 32'h5);
        for (int c = 0; c < 6; c++) begin
            if (req_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk("R9", "no request for unsupported mode", 32'(seen), 32'h0);
        wait_idle("R9");
        chk_flags("R9", 1'b0, 1'b0, 1'b1);
        chk("R10", "word kept, enable cleared", cmd_word, w & ~EN);
    endtask

    task automatic t_noen;
        bit seen = 1'b0;
        write_cmd(RSP | 32'd9, 32'h9);
        for (int c = 0; c < 6; c++) begin
            if (req_valid || busy) seen = 1'b1;
            @(negedge clk);
        end
        chk("R10", "no request without enable", 32'(seen), 32'h0);
        chk("R10", "stored word", cmd_word, RSP | 32'd9);
        chk_flags("R10", 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; cmd_arg = '0; req_ready = 1'b0;
        rply_valid = 1'b0; rply_byte = '0; rply_last = 1'b0; rply_empty = 1'b0; rply_reject = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_long(EN | RSP | LNG | 32'd2);
        t_sent();
        t_bad(EN | RSP | LNG | 32'd9, 4, 0, "R4");
        t_bad(EN | RSP | 32'd13, 0, 1, "R4");
        t_bad(EN | RSP | 32'd13, 5, 0, "R4");
        t_bad(EN | RSP | LNG | 32'd13, 17, 0, "R4");
        t_bad(EN | 32'd7, 0, 2, "R8");
        t_bad(EN | RSP | 32'd7, 0, 2, "R8");
        t_long(EN | RSP | 32'd3);
        t_unsup(INTR);
        t_noen();
        t_unsup(PEND);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule